// File: doc/BRIEF.md
# SPI Master Shifter with Clock-Halt Freeze

This block is the master side of a byte-wide SPI port. Software side logic writes one byte into the transmit path. That write starts a transfer: the block drives a serial clock, shifts the byte out most significant bit first on the data-out line, and collects eight bits from the data-in line at the same time. When the eighth bit is in, the received byte is placed in a read buffer. A completion flag is raised, and it can request a wake-up from a low-power state.

A clock-enable input stands for the module clock being stopped during sleep. While it is low, every part of the transfer engine keeps its value: the bit position, the serial clock level and the output data all hold. When the enable returns, the byte carries on from the same half-bit and no data is lost. Three control inputs select the serial mode: clock idle level, which edge launches data, and whether input data is sampled mid-bit or at the end of the bit. A single active-low select output is low while a byte is on the wire.

Top module: `spim_top`

## Requirements
- R1: After reset, cs_n is 1, sck equals cpol, and buf_full, wr_coll, rx_ovf, irq_flag, wake and rd_data are all 0.
- R2: A write with port_en=1 while idle starts a transfer. cs_n is low for 16 half-bits of DIV enabled cycles each. mosi sends wr_data MSB first. rd_data ends up holding the 8 bits seen on miso, first bit in bit 7. Whenever cs_n is 1, sck equals cpol.
- R3: With early_out=1, sck stays at cpol for the first half-bit, and mosi changes on active-to-idle edges. With early_out=0, sck goes to ~cpol in the first cycle of the transfer, and mosi changes on idle-to-active edges.
- R4: With late_samp=0, miso is sampled at the middle of each bit, on the sck edge between the bit's two halves. With late_samp=1, it is sampled at the end of the bit, on the edge where the next bit is launched.
- R5: While clk_en is 0, sck, mosi and cs_n hold and no completion occurs. When clk_en returns, the transfer resumes and delivers the same data as an unpaused one.
- R6: A write while cs_n is 0 sets wr_coll, and leaves the byte on the wire unchanged. wcol_clr clears wr_coll.
- R7: Completion with buf_full=0 loads rd_data and sets buf_full. A rd_en pulse clears buf_full.
- R8: Completion while buf_full=1 sets rx_ovf and leaves rd_data unchanged. ovf_clr clears rx_ovf.
- R9: Every completion sets irq_flag, which irq_clr clears. wake is 1 exactly when irq_flag and irq_en are both 1.
- R10: Asserting rst_n low in the middle of a transfer returns cs_n to 1 and sck to cpol, and that transfer never raises irq_flag.
- R11: port_en=0 abandons a transfer in progress within one cycle. A write made while port_en=0 does not start a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Module clock running; 0 freezes the transfer engine |
| port_en | input | 1 | Port enable; 0 abandons a transfer and blocks starts |
| cpol | input | 1 | Idle level of sck |
| early_out | input | 1 | 1: first bit valid before the leading edge; 0: data launched on leading edges |
| late_samp | input | 1 | 1: sample miso at end of bit; 0: mid-bit |
| wr_en | input | 1 | Write strobe for the transmit byte |
| wr_data | input | DW | Byte to transmit |
| rd_en | input | 1 | Read strobe; clears buf_full |
| rd_data | output | DW | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| wr_coll | output | 1 | Write collided with an active transfer |
| rx_ovf | output | 1 | Byte completed while buffer was full |
| irq_flag | output | 1 | Transfer-complete flag |
| irq_en | input | 1 | Lets irq_flag drive wake |
| wake | output | 1 | Wake request |
| irq_clr | input | 1 | Clears irq_flag |
| wcol_clr | input | 1 | Clears wr_coll |
| ovf_clr | input | 1 | Clears rx_ovf |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low select, low during a transfer |

## Verification
Some properties are checked on every cycle:
- sck sits at its idle level whenever the select is high.
- A frozen engine keeps sck, mosi and the select steady.
- A colliding write raises the collision flag.
- An overflow never disturbs the buffered byte.
- Dropping the port enable returns the select high.
- wake stays low when the interrupt enable is off.

Other behaviours need bench scenarios: the data delivered in all four clock modes, the choice of sampling point, resuming after a freeze without loss, and abandoning a transfer on reset. For the sampling point, a slave model corrupts miso in the second half of each bit, so mid-bit and end-of-bit sampling produce different bytes.

// File: rtl/spim_pkg.sv
package spim_pkg;

    // Status flags kept by the buffer/status unit.
    typedef struct packed {
        logic full;
        logic wcol;
        logic ovf;
        logic irq;
    } spim_flags_t;

    localparam spim_flags_t SPIM_FLAGS_RST = '{full: 1'b0, wcol: 1'b0, ovf: 1'b0, irq: 1'b0};

endpackage

// File: rtl/spim_tick.sv
// Fixed divider: one tick per DIV enabled cycles while a transfer runs.
module spim_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic busy,
    input  logic clk_en,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } tick_st_t;

    tick_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!busy) begin
            st_d.cnt = '0;
        end else if (clk_en) begin
            st_d.cnt = (st_q.cnt == LAST) ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tick = busy && clk_en && (st_q.cnt == LAST);

endmodule

// File: rtl/spim_seq.sv
// Half-bit sequencer: transfer state, half-bit index and serial clock.
module spim_seq #(
    parameter int DW = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic port_en,
    input  logic tick,
    input  logic cpol,
    input  logic early_out,
    output logic busy,
    output logic ph_odd,
    output logic done,
    output logic sck
);
    localparam int HALVES = 2 * DW;
    localparam int PW = $clog2(HALVES);
    localparam logic [PW-1:0] PH_LAST = PW'(HALVES - 1);

    typedef struct packed {
        logic          busy;
        logic [PW-1:0] ph;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!port_en) begin
            st_d.busy = 1'b0;
            st_d.ph   = '0;
        end else if (start) begin
            st_d.busy = 1'b1;
            st_d.ph   = '0;
        end else if (tick) begin
            if (st_q.ph == PH_LAST) begin
                st_d.busy = 1'b0;
                st_d.ph   = '0;
            end else begin
                st_d.ph = st_q.ph + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy   = st_q.busy;
    assign ph_odd = st_q.ph[0];
    assign done   = tick && port_en && (st_q.ph == PH_LAST);

    // early_out=1: even halves idle, odd halves active.
    // early_out=0: even halves active, odd halves idle.
    always_comb begin
        if (st_q.busy) sck = cpol ^ (early_out ? st_q.ph[0] : ~st_q.ph[0]);
        else           sck = cpol;
    end

endmodule

// File: rtl/spim_shift.sv
// Transmit and receive shift registers.
module spim_shift #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] load_data,
    input  logic          tick,
    input  logic          ph_odd,
    input  logic          late_samp,
    input  logic          miso,
    output logic          mosi,
    output logic [DW-1:0] rx_next
);
    typedef struct packed {
        logic [DW-1:0] tx;
        logic [DW-1:0] rx;
    } sh_st_t;

    sh_st_t st_d, st_q;
    logic   sample;
    logic   launch;

    // Mid-bit sample closes an even half; end-of-bit sample closes an odd half.
    assign sample  = tick && (late_samp ? ph_odd : !ph_odd);
    assign launch  = tick && ph_odd;
    assign rx_next = sample ? {st_q.rx[DW-2:0], miso} : st_q.rx;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.tx = load_data;
            st_d.rx = '0;
        end else begin
            if (launch) st_d.tx = {st_q.tx[DW-2:0], 1'b0};
            st_d.rx = rx_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mosi = st_q.tx[DW-1];

endmodule

// File: rtl/spim_status.sv
// Receive buffer and sticky status flags.
module spim_status
    import spim_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          busy,
    input  logic          rd_en,
    input  logic          done,
    input  logic [DW-1:0] rx_next,
    input  logic          irq_clr,
    input  logic          wcol_clr,
    input  logic          ovf_clr,
    output logic [DW-1:0] rbuf,
    output spim_flags_t   flags
);
    typedef struct packed {
        logic [DW-1:0] rbuf;
        spim_flags_t   fl;
    } stat_st_t;

    stat_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en)    st_d.fl.full = 1'b0;
        if (wcol_clr) st_d.fl.wcol = 1'b0;
        if (ovf_clr)  st_d.fl.ovf  = 1'b0;
        if (irq_clr)  st_d.fl.irq  = 1'b0;
        if (wr_en && busy) st_d.fl.wcol = 1'b1;
        if (done) begin
            st_d.fl.irq = 1'b1;
            if (st_q.fl.full) begin
                st_d.fl.ovf = 1'b1;
            end else begin
                st_d.rbuf = rx_next;
            end
            st_d.fl.full = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.rbuf <= '0;
            st_q.fl   <= SPIM_FLAGS_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign rbuf  = st_q.rbuf;
    assign flags = st_q.fl;

endmodule

// File: rtl/spim_top.sv
module spim_top
    import spim_pkg::*;
#(
    parameter int DW  = 8,
    parameter int DIV = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clk_en,
    input  logic          port_en,
    input  logic          cpol,
    input  logic          early_out,
    input  logic          late_samp,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          buf_full,
    output logic          wr_coll,
    output logic          rx_ovf,
    output logic          irq_flag,
    input  logic          irq_en,
    output logic          wake,
    input  logic          irq_clr,
    input  logic          wcol_clr,
    input  logic          ovf_clr,
    output logic          sck,
    output logic          mosi,
    input  logic          miso,
    output logic          cs_n
);
    logic          busy;
    logic          tick;
    logic          ph_odd;
    logic          done;
    logic          start;
    logic [DW-1:0] rx_next;
    spim_flags_t   flags;

    assign start = wr_en && !busy && port_en;

    spim_tick #(.DIV(DIV)) tick_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .busy   (busy),
        .clk_en (clk_en),
        .tick   (tick)
    );

    spim_seq #(.DW(DW)) seq_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .port_en   (port_en),
        .tick      (tick),
        .cpol      (cpol),
        .early_out (early_out),
        .busy      (busy),
        .ph_odd    (ph_odd),
        .done      (done),
        .sck       (sck)
    );

    spim_shift #(.DW(DW)) shift_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (start),
        .load_data (wr_data),
        .tick      (tick),
        .ph_odd    (ph_odd),
        .late_samp (late_samp),
        .miso      (miso),
        .mosi      (mosi),
        .rx_next   (rx_next)
    );

    spim_status #(.DW(DW)) status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .busy     (busy),
        .rd_en    (rd_en),
        .done     (done),
        .rx_next  (rx_next),
        .irq_clr  (irq_clr),
        .wcol_clr (wcol_clr),
        .ovf_clr  (ovf_clr),
        .rbuf     (rd_data),
        .flags    (flags)
    );

    assign buf_full = flags.full;
    assign wr_coll  = flags.wcol;
    assign rx_ovf   = flags.ovf;
    assign irq_flag = flags.irq;
    assign wake     = flags.irq && irq_en;
    assign cs_n     = !busy;

endmodule

// File: rtl/spim_top_chk.sv
module spim_top_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clk_en,
    input logic          port_en,
    input logic          cpol,
    input logic          wr_en,
    input logic [DW-1:0] rd_data,
    input logic          wr_coll,
    input logic          rx_ovf,
    input logic          irq_flag,
    input logic          irq_en,
    input logic          wake,
    input logic          sck,
    input logic          mosi,
    input logic          cs_n
);
    // R2
    sck_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (sck == cpol));

    // R5
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en && port_en && !cs_n) |=> ($stable(sck) && $stable(mosi) && !cs_n));

    // R6
    coll_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cs_n) |=> wr_coll);

    // R8
    ovf_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovf) |-> $stable(rd_data));

    // R9
    wake_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !wake);

    // R9
    irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_flag) |-> $past(!cs_n));

    // R11
    port_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !port_en |=> cs_n);

endmodule

bind spim_top spim_top_chk #(.DW(DW)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .port_en  (port_en),
    .cpol     (cpol),
    .wr_en    (wr_en),
    .rd_data  (rd_data),
    .wr_coll  (wr_coll),
    .rx_ovf   (rx_ovf),
    .irq_flag (irq_flag),
    .irq_en   (irq_en),
    .wake     (wake),
    .sck      (sck),
    .mosi     (mosi),
    .cs_n     (cs_n)
);

// File: tb/spim_top_tb_top.sv
module spim_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_en = 1'b1;
    logic       port_en = 1'b1;
    logic       cpol = 1'b0;
    logic       early_out = 1'b1;
    logic       late_samp = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic       buf_full, wr_coll, rx_ovf, irq_flag, wake;
    logic       irq_en = 1'b0;
    logic       irq_clr = 1'b0, wcol_clr = 1'b0, ovf_clr = 1'b0;
    logic       sck, mosi, cs_n;
    logic       miso = 1'b0;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    spim_top #(.DW(8), .DIV(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .port_en(port_en),
        .cpol(cpol), .early_out(early_out), .late_samp(late_samp),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .buf_full(buf_full), .wr_coll(wr_coll), .rx_ovf(rx_ovf),
        .irq_flag(irq_flag), .irq_en(irq_en), .wake(wake), .irq_clr(irq_clr),
        .wcol_clr(wcol_clr), .ovf_clr(ovf_clr), .sck(sck), .mosi(mosi),
        .miso(miso), .cs_n(cs_n)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- slave model ----------------
    logic [7:0] sb = 8'h00;
    logic [7:0] mcap = 8'h00;
    bit         glitch = 1'b0;
    int         sidx = 7;
    logic       prev_cs = 1'b1;
    logic       prev_sck = 1'b0;

    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            sidx = 7;
            miso = sb[7];
            mcap = 8'h00;
        end else if ((!cs_n || !prev_cs) && sck != prev_sck) begin
            // Capture edge is the mid-bit edge: leading for early_out=1, trailing otherwise.
            if ((sck != cpol) == early_out) begin
                mcap = {mcap[6:0], mosi};
                if (glitch) miso = ~miso;
            end else if (sidx > 0) begin
                sidx = sidx - 1;
                miso = sb[sidx];
            end
        end
        prev_cs  = cs_n;
        prev_sck = sck;
    end

    // ---------------- scoreboard ----------------
    typedef struct {
        logic [7:0] rd;
        logic [7:0] tx;
    } exp_t;
    exp_t exq[$];
    logic prev_irq = 1'b0;
    bit   pend = 1'b0;

    always @(negedge clk) begin
        if (pend) begin
            if (exq.size() == 0) begin
                chk(1'b0, "R2 unexpected completion", 32'(rd_data), 0);
            end else begin
                exp_t e;
                e = exq.pop_front();
                chk(rd_data == e.rd, "R2/R4/R8 rd_data", 32'(rd_data), 32'(e.rd));
                chk(mcap == e.tx, "R2/R6 mosi byte", 32'(mcap), 32'(e.tx));
            end
        end
        pend = irq_flag && !prev_irq;
        prev_irq = irq_flag;
    end

    // ---------------- driver ----------------
    task automatic xfer(input logic [7:0] tx, input logic [7:0] srx, input logic [7:0] exp_rd,
                        input bit do_read, input int pause_at, input bit collide);
        exp_t e;
        logic s0, m0;
        sb = srx;
        e.rd = exp_rd;
        e.tx = tx;
        exq.push_back(e);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = tx;
        @(negedge clk);
        wr_en = 1'b0;
        chk(cs_n == 1'b0, "R2 cs_n low", 32'(cs_n), 0);
        // R3: first half-bit level depends on early_out
        chk(sck == (early_out ? cpol : ~cpol), "R3 first half sck", 32'(sck), 32'(early_out ? cpol : ~cpol));
        if (collide) begin
            repeat (4) @(negedge clk);
            wr_en = 1'b1;
            wr_data = 8'hFF;
            @(negedge clk);
            wr_en = 1'b0;
            chk(wr_coll == 1'b1, "R6 wr_coll set", 32'(wr_coll), 1);
        end
        if (pause_at > 0) begin
            repeat (pause_at) @(negedge clk);
            clk_en = 1'b0;
            @(negedge clk);
            s0 = sck;
            m0 = mosi;
            repeat (20) @(negedge clk);
            chk(sck == s0 && mosi == m0 && !cs_n && !irq_flag, "R5 frozen",
                {sck, mosi, cs_n, irq_flag}, {s0, m0, 2'b00});
            clk_en = 1'b1;
        end
        while (!irq_flag) @(negedge clk);
        chk(buf_full == 1'b1, "R7 buf_full set", 32'(buf_full), 1);
        chk(wake == irq_en, "R9 wake", 32'(wake), 32'(irq_en));
        @(negedge clk);
        irq_clr = 1'b1;
        rd_en = do_read;
        @(negedge clk);
        irq_clr = 1'b0;
        rd_en = 1'b0;
        chk(irq_flag == 1'b0 && wake == 1'b0, "R9 irq cleared", {irq_flag, wake}, 0);
        if (do_read) chk(buf_full == 1'b0, "R7 buf_full cleared", 32'(buf_full), 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(cs_n == 1'b1 && sck == 1'b0, "R1 pins in reset", {cs_n, sck}, 2'b10);
        rst_n = 1'b1;
        @(negedge clk);
        chk({buf_full, wr_coll, rx_ovf, irq_flag, wake} == 5'b0 && rd_data == 8'h00,
            "R1 status after reset", {buf_full, wr_coll, rx_ovf, irq_flag, wake, rd_data}, 0);

        // R2/R3: four clock modes
        cpol = 1'b0; early_out = 1'b1; @(negedge clk);
        chk(sck == cpol, "R2 idle sck", 32'(sck), 32'(cpol));
        xfer(8'hA5, 8'h5A, 8'h5A, 1, 0, 0);
        cpol = 1'b0; early_out = 1'b0; @(negedge clk);
        xfer(8'h81, 8'hC3, 8'hC3, 1, 0, 0);
        cpol = 1'b1; early_out = 1'b1; @(negedge clk);
        chk(sck == cpol, "R2 idle sck high", 32'(sck), 32'(cpol));
        xfer(8'h3E, 8'h17, 8'h17, 1, 0, 0);
        cpol = 1'b1; early_out = 1'b0; @(negedge clk);
        xfer(8'hE1, 8'h96, 8'h96, 1, 0, 0);

        // R4: miso flipped after the mid-bit edge
        glitch = 1'b1;
        cpol = 1'b0; early_out = 1'b1; late_samp = 1'b0;
        xfer(8'h0F, 8'h6B, 8'h6B, 1, 0, 0);
        late_samp = 1'b1;
        xfer(8'hF0, 8'h6B, 8'h94, 1, 0, 0);
        early_out = 1'b0;
        xfer(8'h55, 8'h2D, 8'hD2, 1, 0, 0);
        glitch = 1'b0;
        late_samp = 1'b0;
        early_out = 1'b1;

        // R5: freeze mid-byte, R9 wake with irq_en set
        irq_en = 1'b1;
        xfer(8'hC6, 8'h39, 8'h39, 1, 9, 0);
        irq_en = 1'b0;

        // R6: collision
        xfer(8'h4B, 8'h72, 8'h72, 1, 0, 1);
        wcol_clr = 1'b1; @(negedge clk); wcol_clr = 1'b0;
        chk(wr_coll == 1'b0, "R6 wr_coll cleared", 32'(wr_coll), 0);

        // R8: overflow keeps old byte
        xfer(8'h11, 8'h3C, 8'h3C, 0, 0, 0);
        xfer(8'h22, 8'hA7, 8'h3C, 0, 0, 0);
        chk(rx_ovf == 1'b1 && buf_full == 1'b1, "R8 overflow flags", {rx_ovf, buf_full}, 2'b11);
        rd_en = 1'b1; ovf_clr = 1'b1; @(negedge clk); rd_en = 1'b0; ovf_clr = 1'b0;
        chk(rx_ovf == 1'b0 && buf_full == 1'b0, "R8/R7 cleared", {rx_ovf, buf_full}, 0);

        // R10: reset mid transfer
        sb = 8'h00;
        wr_en = 1'b1; wr_data = 8'h99; @(negedge clk); wr_en = 1'b0;
        repeat (10) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1 && sck == cpol, "R10 abort on reset", {cs_n, sck}, {1'b1, cpol});
        rst_n = 1'b1;
        repeat (40) @(negedge clk);
        chk(irq_flag == 1'b0 && cs_n == 1'b1, "R10 no completion", {irq_flag, cs_n}, 2'b01);

        // R11: port disabled
        port_en = 1'b0;
        wr_en = 1'b1; wr_data = 8'h77; @(negedge clk); wr_en = 1'b0;
        chk(cs_n == 1'b1, "R11 write ignored", 32'(cs_n), 1);
        port_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b1; wr_data = 8'h77; @(negedge clk); wr_en = 1'b0;
        repeat (6) @(negedge clk);
        port_en = 1'b0;
        @(negedge clk);
        chk(cs_n == 1'b1 && sck == cpol, "R11 abandon", {cs_n, sck}, {1'b1, cpol});
        repeat (40) @(negedge clk);
        chk(irq_flag == 1'b0, "R11 no completion", 32'(irq_flag), 0);
        port_en = 1'b1;
        chk(exq.size() == 0, "R2 all completions seen", exq.size(), 0);

        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule